// File: doc/BRIEF.md
# Exponent-Aligning Fraction Adder/Subtractor

This combinational block adds or subtracts two numbers held in a redundant base-two scientific format. Each 32-bit word packs a signed exponent and a signed fraction, and both are two's complement. The value of a word is fraction × 2^exponent. The block compares the two exponents and moves the fraction of the operand with the smaller exponent right until both share the larger exponent. It then adds the two aligned fractions, or subtracts the second from the first, and packs the result fraction with the larger exponent.

The format has no hidden bit, and fractions are never renormalised, so a value may have several encodings. Alignment uses an arithmetic shift. Bits pushed off the low end of the smaller operand are dropped and no flag reports their loss. The caller gets the raw carry-out of the fraction adder and a signed overflow flag, and decides what to do with them. The block has no registers, so its outputs follow its inputs within the same cycle.

Top module: `fmt_align_addsub`

## Requirements
- R1: An operand word carries a signed 8-bit exponent in bits [31:24] and a signed 24-bit fraction in bits [23:0]. The result word uses the same layout.
- R2: The result exponent is the larger of the two input exponents, compared as signed values.
- R3: When the exponents are equal, neither fraction is shifted. The result fraction is A+B (add) or A−B (subtract), taken modulo 2^24.
- R4: When the exponents differ, the fraction of the operand with the smaller exponent is arithmetically shifted right by the exponent difference, so its sign bit fills the vacated positions. The other fraction is used unchanged.
- R5: When the exponent difference is 24 or more, the shifted fraction becomes all sign bits: 0 for a non-negative fraction and all ones (−1) for a negative one. This holds up to the widest difference of 255.
- R6: With `sub_sel`=1, the result fraction is the aligned A fraction minus the aligned B fraction. Alignment is the same as for addition, whichever operand is shifted.
- R7: `carry_out` is the carry out of bit 23 of the fraction adder. For an add, it is 1 exactly when the aligned fractions, read as unsigned 24-bit numbers, sum to 2^24 or more. For a subtract, it is 1 exactly when unsigned aligned A ≥ unsigned aligned B (no borrow).
- R8: `ovf` is 1 exactly when the true signed result of the aligned fractions falls outside [−2^23, 2^23−1]. This is the case when the two adder inputs share a sign and the result fraction's sign differs from it.
- R9: Bits shifted out of the smaller operand are discarded silently. They affect neither `carry_out` nor `ovf`.
- R10: The block holds no state. Outputs depend only on the present inputs, and all-zero inputs give an all-zero result with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand word: exponent [31:24], fraction [23:0] |
| op_b | input | 32 | Second operand word, same layout |
| sub_sel | input | 1 | 0 = A+B, 1 = A−B |
| res | output | 32 | Result word: larger exponent and result fraction |
| carry_out | output | 1 | Carry out of the fraction adder |
| ovf | output | 1 | Signed overflow of the fraction add or subtract |

## Verification
The assertions run on every input change and check the following:
- The result exponent is the signed maximum of the two input exponents.
- With equal exponents, the fraction sum or difference is exact.
- An operand shifted by 24 or more becomes pure sign fill.
- Subtracting an operand from itself gives zero with the carry set.
- When A holds the larger exponent, an overflow flips the result's sign away from A's.

Only the bench's scenarios show the following:
- The exact arithmetic-shift result for differences from 1 to 23, for either operand and for negative fractions.
- Silent loss of shifted-out bits.
- The unsigned carry rule.
- Behaviour at the signed exponent extremes.

// File: rtl/fpadd_pkg.sv
// fpadd_pkg: field widths and the packed word layout shared by the
// exponent-aligning adder/subtractor and its checker.
// Assumes exponent above fraction in the word, both two's complement.
package fpadd_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 24;
    parameter int WORD_W = EXP_W + FRAC_W;
    parameter int GRP_W  = 8;

    typedef struct packed {
        logic signed [EXP_W-1:0]  ex;
        logic signed [FRAC_W-1:0] fr;
    } fword_t;
endpackage

// File: rtl/exp_compare.sv
// exp_compare: compares two signed exponents. It returns the larger one,
// which side owns it, and the unsigned magnitude of their difference.
// Assumes signed inputs; the difference is one bit wider so it cannot wrap.
module exp_compare #(
    parameter int EXP_W = 8,
    localparam int DIF_W = EXP_W + 1
) (
    input  logic signed [EXP_W-1:0] ea,
    input  logic signed [EXP_W-1:0] eb,
    output logic                    a_big,
    output logic signed [EXP_W-1:0] ex_max,
    output logic        [DIF_W-1:0] mag
);
    logic signed [DIF_W-1:0] diff;

    // purpose: widen both exponents and form the signed difference
    always_comb begin
        diff = DIF_W'(ea) - DIF_W'(eb);
    end

    // purpose: choose the winning exponent and the absolute shift distance
    always_comb begin
        a_big  = (ea >= eb);
        ex_max = a_big ? ea : eb;
        mag    = a_big ? diff : -diff;
    end
endmodule

// File: rtl/frac_align.sv
// frac_align: arithmetic right shifter for a signed fraction.
// Shifts of FRAC_W or more saturate to pure sign fill.
// Assumes the shift amount is an unsigned magnitude.
module frac_align #(
    parameter int FRAC_W = 24,
    parameter int SH_W   = 9,
    localparam int STG   = $clog2(FRAC_W)
) (
    input  logic signed [FRAC_W-1:0] din,
    input  logic        [SH_W-1:0]   shamt,
    output logic signed [FRAC_W-1:0] dout
);
    logic [FRAC_W-1:0] stage [0:STG];
    logic              wide;

    assign stage[0] = din;

    // purpose: one barrel stage per bit of the shift amount, sign-filling
    for (genvar i = 0; i < STG; i++) begin : g_stage
        localparam int D = 1 << i;
        assign stage[i+1] = shamt[i]
            ? {{D{stage[i][FRAC_W-1]}}, stage[i][FRAC_W-1:D]}
            : stage[i];
    end

    // purpose: flag distances that leave only the sign bit
    always_comb begin
        wide = (shamt >= SH_W'(FRAC_W));
    end

    // purpose: select saturated sign fill or the barrel result
    always_comb begin
        dout = wide ? {FRAC_W{din[FRAC_W-1]}} : stage[STG];
    end
endmodule

// File: rtl/csel_adder.sv
// csel_adder: carry-select adder built from equal groups. Each group
// precomputes its sum for carry-in 0 and 1, and the incoming carry picks one.
// Assumes W is a multiple of GRP.
module csel_adder #(
    parameter int W   = 24,
    parameter int GRP = 8,
    localparam int NGRP = W / GRP
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [NGRP:0] c;

    assign c[0] = cin;

    // purpose: per-group speculative sums and carry selection
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP:0] s0, s1;
        assign s0 = {1'b0, a[g*GRP +: GRP]} + {1'b0, b[g*GRP +: GRP]};
        assign s1 = {1'b0, a[g*GRP +: GRP]} + {1'b0, b[g*GRP +: GRP]} + (GRP+1)'(1);
        assign sum[g*GRP +: GRP] = c[g] ? s1[GRP-1:0] : s0[GRP-1:0];
        assign c[g+1]            = c[g] ? s1[GRP]     : s0[GRP];
    end

    assign cout = c[NGRP];
endmodule

// File: rtl/fmt_align_addsub.sv
// fmt_align_addsub: adds or subtracts two exponent/fraction words. The
// fraction with the smaller exponent is aligned by an arithmetic right
// shift, and the result carries the larger exponent. Purely combinational.
// Assumes no renormalisation; lost low bits are not reported.
module fmt_align_addsub
    import fpadd_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int F_W = FRAC_W,
    parameter int G_W = GRP_W,
    localparam int W_W  = E_W + F_W,
    localparam int SH_W = E_W + 1
) (
    input  logic [W_W-1:0] op_a,
    input  logic [W_W-1:0] op_b,
    input  logic           sub_sel,
    output logic [W_W-1:0] res,
    output logic           carry_out,
    output logic           ovf
);
    logic signed [E_W-1:0]  ea, eb, ex_max;
    logic signed [F_W-1:0]  fa, fb, fa_al, fb_al;
    logic        [F_W-1:0]  addend, sum;
    logic        [SH_W-1:0] mag, sh_a, sh_b;
    logic                   a_big;

    // purpose: split each word into its exponent and fraction fields
    always_comb begin
        ea = op_a[W_W-1:F_W];
        eb = op_b[W_W-1:F_W];
        fa = op_a[F_W-1:0];
        fb = op_b[F_W-1:0];
    end

    exp_compare #(.EXP_W(E_W)) u_cmp (
        .ea(ea), .eb(eb), .a_big(a_big), .ex_max(ex_max), .mag(mag)
    );

    // purpose: steer the shift distance to the smaller-exponent side only
    always_comb begin
        sh_a = a_big ? '0  : mag;
        sh_b = a_big ? mag : '0;
    end

    frac_align #(.FRAC_W(F_W), .SH_W(SH_W)) u_al_a (
        .din(fa), .shamt(sh_a), .dout(fa_al)
    );
    frac_align #(.FRAC_W(F_W), .SH_W(SH_W)) u_al_b (
        .din(fb), .shamt(sh_b), .dout(fb_al)
    );

    // purpose: invert the aligned B fraction for subtraction (+1 via carry-in)
    always_comb begin
        addend = sub_sel ? ~fb_al : fb_al;
    end

    csel_adder #(.W(F_W), .GRP(G_W)) u_add (
        .a(fa_al), .b(addend), .cin(sub_sel), .sum(sum), .cout(carry_out)
    );

    // purpose: signed overflow from adder-input signs against the sum sign
    always_comb begin
        ovf = (fa_al[F_W-1] == addend[F_W-1]) && (sum[F_W-1] != fa_al[F_W-1]);
    end

    // purpose: pack the larger exponent with the result fraction
    always_comb begin
        res = {ex_max, sum};
    end
endmodule

// File: rtl/fpadd_chk.sv
// fpadd_chk: port-level checker for fmt_align_addsub. It evaluates its
// properties whenever the inputs or outputs change. Assumes default widths.
module fpadd_chk
    import fpadd_pkg::*;
(
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              sub_sel,
    input logic [WORD_W-1:0] res,
    input logic              carry_out,
    input logic              ovf
);
    fword_t a_w, b_w, r_w;
    int     ea, eb;
    logic [FRAC_W-1:0] exact, fill;

    // purpose: decode fields and prepare reference quantities
    always_comb begin
        a_w   = op_a;
        b_w   = op_b;
        r_w   = res;
        ea    = int'(a_w.ex);
        eb    = int'(b_w.ex);
        exact = sub_sel ? (a_w.fr - b_w.fr) : (a_w.fr + b_w.fr);
        fill  = a_w.fr + {FRAC_W{b_w.fr[FRAC_W-1]}};
    end

    // purpose: combinational properties over the block's ports
    always_comb begin
        p_exp_max_r2: assert (int'(r_w.ex) == ((ea >= eb) ? ea : eb))
            else $error("R2 result exponent is not the signed maximum");
        p_equal_noshift_r3: assert (!(ea == eb) || (r_w.fr == exact))
            else $error("R3 equal-exponent fraction mismatch");
        p_wide_fill_r5: assert (!((ea - eb) >= FRAC_W && !sub_sel) || (r_w.fr == fill))
            else $error("R5 wide shift did not reduce to sign fill");
        p_sub_self_r7: assert (!(sub_sel && op_a == op_b) || (r_w.fr == '0 && carry_out))
            else $error("R7 self-subtraction not zero with carry");
        p_ovf_sign_r8: assert (!(ovf && ea >= eb) || (r_w.fr[FRAC_W-1] != a_w.fr[FRAC_W-1]))
            else $error("R8 overflow without sign change against A");
    end
endmodule

bind fmt_align_addsub fpadd_chk u_chk (
    .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
    .res(res), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/sim_fmt_align_addsub.sv
// sim_fmt_align_addsub: self-checking bench with a behavioural reference
// model in integer arithmetic. Inputs change just after a rising edge and
// outputs are compared at the following falling edge.
module sim_fmt_align_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        sub_sel = 1'b0;
    logic [31:0] res;
    logic        carry_out, ovf;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fmt_align_addsub u0 (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
        .res(res), .carry_out(carry_out), .ovf(ovf)
    );

    // purpose: reference model from the requirements, integer arithmetic
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic s,
                         output logic [31:0] r, output logic c, output logic o);
        int ea, eb, fa, fb, d, rv;
        longint ua, ub;
        ea = int'($signed(a[31:24]));
        eb = int'($signed(b[31:24]));
        fa = int'($signed(a[23:0]));
        fb = int'($signed(b[23:0]));
        d  = ea - eb;
        if (d > 0)      fb = (d >= 24) ? ((fb < 0) ? -1 : 0) : (fb >>> d);
        else if (d < 0) fa = (-d >= 24) ? ((fa < 0) ? -1 : 0) : (fa >>> -d);
        rv = s ? (fa - fb) : (fa + fb);
        r  = {(ea >= eb) ? a[31:24] : b[31:24], rv[23:0]};
        o  = (rv > 8388607) || (rv < -8388608);
        ua = longint'(fa) & 64'hFFFFFF;
        ub = longint'(fb) & 64'hFFFFFF;
        c  = s ? (ua >= ub) : ((ua + ub) >= 64'h1000000);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // purpose: apply one vector and compare all outputs against the model
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
        logic [31:0] er;
        logic ec, eo;
        @(posedge clk); #1;
        op_a = a; op_b = b; sub_sel = s;
        @(negedge clk);
        model(a, b, s, er, ec, eo);
        chk(tag, "res", res, er);
        chk(tag, "carry", {31'b0, carry_out}, {31'b0, ec});
        chk(tag, "ovf", {31'b0, ovf}, {31'b0, eo});
    endtask

    initial begin
        // watchdog: a hung run counts as a failure
        #400000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset res", res, 32'h0);
        chk("R10", "reset flags", {30'b0, carry_out, ovf}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        run({8'h05, 24'h000100}, {8'h05, 24'h000023}, 1'b0, "R3");
        run({8'h05, 24'h000100}, {8'h05, 24'hFFFF00}, 1'b0, "R1");
        run({8'h04, 24'h000800}, {8'h01, 24'h000040}, 1'b0, "R4");
        run({8'h04, 24'h000800}, {8'h01, 24'hFFFFC0}, 1'b0, "R4");
        run({8'hFD, 24'hFFF001}, {8'h02, 24'h000010}, 1'b0, "R4");
        run({8'hFB, 24'h000010}, {8'hFE, 24'h000001}, 1'b0, "R2");
        run({8'h20, 24'h000005}, {8'h02, 24'h812345}, 1'b0, "R5");
        run({8'h18, 24'h000005}, {8'h00, 24'h812345}, 1'b0, "R5");
        run({8'h17, 24'h000005}, {8'h00, 24'h812345}, 1'b0, "R5");
        run({8'h80, 24'hC00000}, {8'h7F, 24'h000007}, 1'b0, "R5");
        run({8'h03, 24'h000100}, {8'h01, 24'h000040}, 1'b1, "R6");
        run({8'hFE, 24'h000100}, {8'h03, 24'h000040}, 1'b1, "R6");
        run({8'h02, 24'h800000}, {8'h02, 24'h800000}, 1'b0, "R7");
        run({8'h02, 24'h123456}, {8'h02, 24'h123456}, 1'b1, "R7");
        run({8'h02, 24'h000010}, {8'h02, 24'h000020}, 1'b1, "R7");
        run({8'h00, 24'h7FFFFF}, {8'h00, 24'h000001}, 1'b0, "R8");
        run({8'h00, 24'h800000}, {8'h00, 24'h000001}, 1'b1, "R8");
        run({8'h14, 24'h000100}, {8'h00, 24'h00FFFF}, 1'b0, "R9");
        run({8'h14, 24'h7FFFFF}, {8'h00, 24'h07FFFF}, 1'b0, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 3 == 0) rb[31:24] = ra[31:24] + 8'($urandom_range(0, 30));
            run(ra, rb, 1'(i % 2), (i % 2) ? "R6" : "R4");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule